// File: doc/BRIEF.md
# Lowest-Priority Interrupt Arbiter

This block settles which processors receive an interrupt message once the destination matchers have flagged the eligible processors. For every request it takes the eligible mask, each processor's 8-bit task priority and a per-processor busy flag. First it removes every processor whose task priority class blocks the interrupt's vector. Then it either broadcasts the message to all remaining processors (fixed delivery) or hands it to exactly one of them (lowest-priority delivery).

In lowest-priority delivery the full 8-bit task priority is compared, including the low sub-priority nibble. A processor that is busy servicing another interrupt is treated as having the worst possible priority. Ties are resolved by a rotating pointer, so repeated interrupts spread over equally idle processors. One processor wins even when several eligible processors share a logical group. The block answers every request a fixed two clock cycles after the strobe, with a one-cycle done pulse. If nobody can take the interrupt, it also raises a one-cycle error flag.

Top module: `irq_lowpri_arbiter`

## Requirements
- R1: Every request strobe sampled at a rising edge produces a one-cycle `done` pulse visible after the second following rising edge. `done` and `no_target` are never high without a preceding strobe.
- R2: With `req_mode` = 3'b001 (lowest priority) and at least one qualified processor, `grant` has exactly one bit set, and that bit belongs to a qualified processor.
- R3: In lowest-priority mode the winner has the numerically smallest effective priority among the qualified processors, compared over all 8 bits, so a difference only in bits [3:0] decides the outcome.
- R4: A processor with its busy flag set takes part with effective priority 0xFF. It therefore loses against any qualified idle processor whose task priority is below 0xFF.
- R5: A processor is qualified only when its eligible bit is set and the vector class `req_vector[7:4]` is strictly greater than its task priority class `tpr[7:4]`. No unqualified processor is ever granted.
- R6: Ties on equal effective priority go to the first tied processor found when scanning upward from the rotating pointer, wrapping from N-1 to 0. The pointer is 0 after reset and becomes (winner+1) mod N after each lowest-priority grant.
- R7: With `req_mode` = 3'b000 (fixed), `grant` equals the full set of qualified processors.
- R8: When no processor is qualified, `grant` stays zero and `no_target` pulses together with `done`.
- R9: Any other mode code yields `done` with `no_target`, a zero `grant`, and leaves the rotating pointer unchanged.
- R10: While reset is high, and in the cycle after it, `grant`, `done` and `no_target` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_mode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority |
| req_vector | input | 8 | Interrupt vector; bits [7:4] are its priority class |
| cpu_elig | input | N_CPU | Per-processor eligible mask from the destination matchers |
| cpu_tpr | input | N_CPU*8 | Task priorities, processor i at bits [8i+7:8i] |
| cpu_busy | input | N_CPU | Per-processor busy flag |
| grant | output | N_CPU | Delivery vector, valid while `done` is high |
| done | output | 1 | One-cycle result pulse |
| no_target | output | 1 | One-cycle pulse: nobody received the interrupt |

## Verification
Every result is due exactly two rising edges after the edge that samples the strobe. The driver stamps each expected item with that cycle number when it pushes it into the scoreboard. The monitor samples on the falling edge and compares the front item only in the cycle whose count matches its stamp. Any `done` or `no_target` seen in another cycle is a latency failure. The expected winner comes from an independent model of the qualification, the 8-bit comparison and the rotating pointer. That model is carried through directed sub-priority, busy, masking and wrap-around cases and then through a run of random requests.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWEST = 3'b001;
endpackage

// File: rtl/irq_arb_qualify.sv
// Per-processor qualification (class masking) and effective priority.
module irq_arb_qualify #(
  parameter int N  = 16,
  parameter int PW = 8
) (
  input  logic [PW-1:0]   vec,
  input  logic [N-1:0]    elig,
  input  logic [N-1:0]    busy,
  input  logic [N*PW-1:0] tpr,
  output logic [N-1:0]    qual,
  output logic [N*PW-1:0] eff
);
  localparam int CW = PW / 2;

  for (genvar g = 0; g < N; g++) begin : g_cpu
    logic [PW-1:0] t;
    assign t = tpr[g*PW +: PW];
    // R5: vector class must be strictly above the task priority class
    assign qual[g] = elig[g] && (vec[PW-1 -: CW] > t[PW-1 -: CW]);
    // R4: a busy processor competes with the worst value
    assign eff[g*PW +: PW] = busy[g] ? {PW{1'b1}} : t;
  end
endmodule

// File: rtl/irq_arb_select.sv
// Minimum search over effective priority, then rotating tie break.
module irq_arb_select #(
  parameter int N  = 16,
  parameter int PW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]    qual,
  input  logic [N*PW-1:0] eff,
  input  logic [IW-1:0]   ptr,
  output logic            any,
  output logic [IW-1:0]   win,
  output logic [N-1:0]    onehot
);
  logic [PW-1:0] minv;
  logic [N-1:0]  cand;
  logic          hit;
  int            idx;

  always_comb begin
    minv = '1;
    for (int i = 0; i < N; i++)
      if (qual[i] && (eff[i*PW +: PW] < minv)) minv = eff[i*PW +: PW];
    for (int i = 0; i < N; i++)
      cand[i] = qual[i] && (eff[i*PW +: PW] == minv);
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    idx = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!hit && cand[idx]) begin
        hit = 1'b1;
        win = IW'(idx);
      end
    end
    onehot = '0;
    if (hit) onehot[win] = 1'b1;
    any = |qual;
  end
endmodule

// File: rtl/irq_lowpri_arbiter.sv
module irq_lowpri_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_CPU  = 16,
  parameter int PRIO_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [2:0]              req_mode,
  input  logic [PRIO_W-1:0]       req_vector,
  input  logic [N_CPU-1:0]        cpu_elig,
  input  logic [N_CPU*PRIO_W-1:0] cpu_tpr,
  input  logic [N_CPU-1:0]        cpu_busy,
  output logic [N_CPU-1:0]        grant,
  output logic                    done,
  output logic                    no_target
);
  localparam int IW = $clog2(N_CPU);
  localparam logic [IW-1:0] LAST = IW'(N_CPU - 1);

  logic [N_CPU-1:0]        q_qual;
  logic [N_CPU*PRIO_W-1:0] q_eff;

  irq_arb_qualify #(.N(N_CPU), .PW(PRIO_W)) u_qual (
    .vec(req_vector), .elig(cpu_elig), .busy(cpu_busy), .tpr(cpu_tpr),
    .qual(q_qual), .eff(q_eff)
  );

  // Stage 1: capture qualified set and effective priorities
  logic                    s1_valid;
  logic [2:0]              s1_mode;
  logic [N_CPU-1:0]        s1_qual;
  logic [N_CPU*PRIO_W-1:0] s1_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mode  <= DM_FIXED;
      s1_qual  <= '0;
      s1_eff   <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_mode <= req_mode;
        s1_qual <= q_qual;
        s1_eff  <= q_eff;
      end
    end
  end

  logic [IW-1:0]    rr_ptr;
  logic             sel_any;
  logic [IW-1:0]    sel_win;
  logic [N_CPU-1:0] sel_onehot;

  irq_arb_select #(.N(N_CPU), .PW(PRIO_W), .IW(IW)) u_sel (
    .qual(s1_qual), .eff(s1_eff), .ptr(rr_ptr),
    .any(sel_any), .win(sel_win), .onehot(sel_onehot)
  );

  // Stage 2: registered result and rotating pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= '0;
      done      <= 1'b0;
      no_target <= 1'b0;
      rr_ptr    <= '0;
    end else begin
      done      <= s1_valid;
      grant     <= '0;
      no_target <= 1'b0;
      if (s1_valid) begin
        case (s1_mode)
          DM_FIXED: begin
            grant     <= s1_qual;
            no_target <= ~|s1_qual;
          end
          DM_LOWEST: begin
            if (sel_any) begin
              grant  <= sel_onehot;
              rr_ptr <= (sel_win == LAST) ? '0 : sel_win + 1'b1;
            end else begin
              no_target <= 1'b1;
            end
          end
          default: no_target <= 1'b1;
        endcase
      end
    end
  end

  // R2: single winner in lowest-priority mode
  p_single_winner_r2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == DM_LOWEST && |s1_qual) |=> ($countones(grant) == 1));

  // R5: only qualified processors can be granted
  p_grant_qualified_r5: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> ((grant & ~$past(s1_qual)) == '0));

  // R1: a result pulse always traces back to a strobe two edges earlier
  p_done_latency_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(req_valid, 2));

  // R8: an error pulse never carries a grant
  p_err_empty_r8: assert property (@(posedge clk) disable iff (rst)
    no_target |-> (grant == '0));

  // R9: non-lowest requests leave the tie pointer alone
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode != DM_LOWEST) |=> $stable(rr_ptr));

  // R7: fixed delivery hands the message to the whole qualified set
  p_fixed_all_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == DM_FIXED) |=> (grant == $past(s1_qual)));
endmodule

// File: tb/sim_irq_lowpri_arbiter.sv
`timescale 1ns/1ps
module sim_irq_lowpri_arbiter;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [2:0]     req_mode = '0;
  logic [7:0]     req_vector = '0;
  logic [N-1:0]   cpu_elig = '0;
  logic [N*8-1:0] cpu_tpr;
  logic [N-1:0]   cpu_busy = '0;
  logic [N-1:0]   grant;
  logic           done;
  logic           no_target;

  logic [7:0] tpr_a [N];

  always_comb
    for (int i = 0; i < N; i++) cpu_tpr[i*8 +: 8] = tpr_a[i];

  irq_lowpri_arbiter #(.N_CPU(N), .PRIO_W(8)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_vector(req_vector), .cpu_elig(cpu_elig), .cpu_tpr(cpu_tpr),
    .cpu_busy(cpu_busy), .grant(grant), .done(done), .no_target(no_target)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [N-1:0] g;
    logic         e;
    int           due;
    int           rq;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int fails  = 0;
  int ptr_m  = 0;
  bit ended  = 0;

  // Reference model built from the requirements
  task automatic send(input logic [2:0] mode, input logic [7:0] vec,
                      input logic [N-1:0] elig, input logic [N-1:0] busy,
                      input int rq);
    exp_t x;
    logic [N-1:0] q;
    int best, w;
    for (int i = 0; i < N; i++)
      q[i] = elig[i] && (vec[7:4] > tpr_a[i][7:4]);
    x.g = '0; x.e = 1'b0; x.rq = rq;
    if (mode == 3'b000) begin
      x.g = q; x.e = (q == '0);
    end else if (mode == 3'b001) begin
      if (q == '0) x.e = 1'b1;
      else begin
        best = 256; w = -1;
        for (int k = 0; k < N; k++) begin
          int j = (ptr_m + k) % N;
          int p = busy[j] ? 255 : int'(tpr_a[j]);
          if (q[j] && p < best) begin best = p; w = j; end
        end
        x.g[w] = 1'b1;
        ptr_m = (w + 1) % N;
      end
    end else begin
      x.e = 1'b1;
    end
    @(negedge clk);
    req_mode = mode; req_vector = vec; cpu_elig = elig; cpu_busy = busy;
    req_valid = 1'b1;
    x.due = cyc + 2;
    sb.push_back(x);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares the front item exactly in its due cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        checks++;
        if (!done || grant !== sb[0].g || no_target !== sb[0].e) begin
          fails++;
          $display("FAIL R%0d: done=%b grant=%h err=%b expected done=1 grant=%h err=%b",
                   sb[0].rq, done, grant, no_target, sb[0].g, sb[0].e);
        end
        void'(sb.pop_front());
      end else if (done || no_target) begin
        checks++; fails++;
        $display("FAIL R1: done=%b err=%b expected done=0 err=0 in cycle %0d",
                 done, no_target, cyc);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) tpr_a[i] = 8'h10;
    repeat (4) @(negedge clk);
    // R10: outputs quiet during reset
    checks++;
    if (grant !== '0 || done !== 1'b0 || no_target !== 1'b0) begin
      fails++;
      $display("FAIL R10: grant=%h done=%b err=%b expected 0 0 0", grant, done, no_target);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (grant !== '0 || done !== 1'b0 || no_target !== 1'b0) begin
      fails++;
      $display("FAIL R10: grant=%h done=%b err=%b after reset expected 0 0 0",
               grant, done, no_target);
    end

    // R3: sub-priority nibble decides (cpu1 0x12 wins)
    tpr_a[0] = 8'h15; tpr_a[1] = 8'h12; tpr_a[2] = 8'h13; tpr_a[3] = 8'h1F;
    send(3'b001, 8'h41, 16'h000F, 16'h0000, 3);
    // R4: busy cpu1 loses, cpu2 0x13 wins
    send(3'b001, 8'h41, 16'h000F, 16'h0002, 4);
    // R5: cpu1 class 4 masked for vector class 3, cpu2 qualifies
    tpr_a[1] = 8'h40; tpr_a[2] = 8'h2E;
    send(3'b001, 8'h31, 16'h0006, 16'h0000, 5);
    // R5: class equal to vector class is masked too
    tpr_a[2] = 8'h30;
    send(3'b001, 8'h31, 16'h0006, 16'h0000, 5);
    // R7: fixed delivery to every qualified cpu, busy ignored
    for (int i = 0; i < N; i++) tpr_a[i] = (i % 3 == 0) ? 8'h70 : 8'h05;
    send(3'b000, 8'h61, 16'hF0F0, 16'h00F0, 7);
    // R8: nothing eligible, fixed and lowest
    send(3'b000, 8'h61, 16'h0000, 16'h0000, 8);
    send(3'b001, 8'h61, 16'h0000, 16'h0000, 8);
    // R8: everyone masked by class
    for (int i = 0; i < N; i++) tpr_a[i] = 8'hF0;
    send(3'b001, 8'hF5, 16'hFFFF, 16'h0000, 8);
    // R6: ties rotate through all equal processors
    for (int i = 0; i < N; i++) tpr_a[i] = 8'h00;
    for (int r = 0; r < 5; r++) send(3'b001, 8'h80, 16'hFFFF, 16'h0000, 6);
    // R6: wrap-around between cpu15 and cpu0 (shared group, one winner)
    for (int r = 0; r < 3; r++) send(3'b001, 8'h80, 16'h8001, 16'h0000, 6);
    // R9: unsupported mode, pointer must stay put (seen by next tie)
    send(3'b010, 8'h80, 16'hFFFF, 16'h0000, 9);
    send(3'b111, 8'h80, 16'hFFFF, 16'h0000, 9);
    send(3'b001, 8'h80, 16'hFFFF, 16'h0000, 9);
    // R4: all busy -> tie among 0xFF, still one winner (R2)
    send(3'b001, 8'h80, 16'h0FF0, 16'hFFFF, 2);
    // R2: random mix
    for (int r = 0; r < 60; r++) begin
      logic [2:0] m;
      int s = $urandom_range(0, 5);
      m = (s == 0) ? 3'b000 : (s == 5) ? 3'b011 : 3'b001;
      for (int i = 0; i < N; i++) tpr_a[i] = 8'($urandom_range(0, 8'h6F));
      send(m, 8'($urandom_range(8'h20, 8'hFF)), 16'($urandom),
           16'($urandom) & 16'($urandom), 2);
    end
    repeat (6) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1: %0d results missing, expected 0", sb.size());
    end
    finish_run();
  end
endmodule